// File: doc/BRIEF.md
# Four-Channel Cycle-Stealing DMA Controller

This block moves single data units between peripheral registers and memory without the CPU. It has four channels. Each channel pairs a fixed peripheral address with a memory address that can step, and each channel keeps its own count and reload values. A channel is triggered either by a software strobe or by a rising edge on one selected peripheral interrupt line.

When a trigger is pending, the controller has priority over the CPU. It takes the shared bus for exactly two cycles: one read from the source address, then one write to the destination address. It then releases the bus. While a transfer is running, or while any request waits, the CPU grant is withheld. Triggers that arrive while a request is already waiting merge into that one request. Because of this, a fast trigger source can produce fewer transfers than triggers.

When a channel's count runs out, its count and memory address are restored from their reload values. A one-cycle terminal-count pulse then marks the end of the block.

Top module: `steal_dma`

## Requirements
- R1: Each of the four channels has six registers, written through the configuration port by channel number and register index: 0 mode, 1 count, 2 count reload, 3 memory address, 4 peripheral address, 5 memory reload. The mode register bits are: [0] direction (0 = peripheral to memory, 1 = memory to peripheral), [1] memory increment enable, [2] unit size (1 = 16-bit, 0 = 8-bit), [3] interrupt-trigger enable, [6:4] interrupt line select.
- R2: A software strobe sampled at clock edge E causes a read cycle (`bus_valid`=1, `bus_we`=0) during the cycle after edge E+1. The write cycle (`bus_we`=1) follows in the next cycle, and the bus is released in the cycle after that.
- R3: With direction 0 the read goes to the peripheral address and the write goes to the memory address. With direction 1 the two addresses are swapped.
- R4: For 16-bit units, `bus_word`=1 and the write data equals the read data. For 8-bit units, `bus_word`=0 and the write data is the low byte of the read data, with the upper byte zero.
- R5: After each transfer that does not expire the count, the memory address advances by 2 for 16-bit units or by 1 for 8-bit units when increment is enabled. It stays unchanged when increment is disabled. The peripheral address never changes.
- R6: Each transfer decrements the count. When the result is zero, the count loads its reload value and the memory address loads its reload value. In that case `tc_pulse[ch]` is high for exactly the one cycle after the write cycle.
- R7: When several channels are pending, the lowest-numbered channel is served first. Consecutive transfers are separated by one idle bus cycle.
- R8: `cpu_gnt` equals `cpu_req` only when the bus is idle and no request is pending. Otherwise `cpu_gnt` is 0.
- R9: With the trigger enable set, a rising edge on the selected `irq_in` line queues one request. A line held high yields only one request. Edges on unselected lines, or edges while the enable is clear, cause no transfer.
- R10: A channel keeps at most one pending request. Triggers arriving while that request waits merge into it, so three strobes issued during one transfer window yield two transfers.
- R11: After reset, the bus is idle, no terminal-count pulse is raised, and `cpu_gnt` follows `cpu_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_idx | input | 3 | Register index within the channel |
| cfg_wdata | input | 16 | Register write data |
| sw_req | input | 4 | Per-channel software trigger strobe |
| irq_in | input | 8 | Peripheral interrupt request lines |
| cpu_req | input | 1 | CPU asks for the shared bus |
| cpu_gnt | output | 1 | Shared bus granted to the CPU |
| bus_valid | output | 1 | Controller drives a bus cycle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of the read cycle |
| tc_pulse | output | 4 | Per-channel terminal-count pulse |

## Verification
Every channel is driven through all eight combinations of direction, increment and unit size, with five transfers each against a count of three and a reload of two. This setting separates address swapping, step size, byte masking and the reload point, which falls at a different transfer on the first pass than on the second. Simultaneous strobes on all channels, and on a sparse subset, expose the service order and the idle gap between transfers. Strobes issued during a transfer window, and interrupt lines held high, toggled on unselected inputs, or toggled with the enable clear, tell merging apart from counting and edges apart from levels.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_state_e;

    // register indices inside one channel
    localparam logic [2:0] RIDX_MODE     = 3'd0;
    localparam logic [2:0] RIDX_COUNT    = 3'd1;
    localparam logic [2:0] RIDX_COUNT_RL = 3'd2;
    localparam logic [2:0] RIDX_MEM      = 3'd3;
    localparam logic [2:0] RIDX_PERIPH   = 3'd4;
    localparam logic [2:0] RIDX_MEM_RL   = 3'd5;

    // mode register bit positions
    localparam int MB_DIR  = 0;
    localparam int MB_INC  = 1;
    localparam int MB_WORD = 2;
    localparam int MB_HWEN = 3;
    localparam int MB_SEL  = 4;

endpackage

// File: rtl/steal_dma_chan.sv
module steal_dma_chan
    import steal_dma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            step,
    output logic            dir_o,
    output logic            word_o,
    output logic            hwen_o,
    output logic [SELW-1:0] sel_o,
    output logic [AW-1:0]   mem_o,
    output logic [AW-1:0]   periph_o,
    output logic            tc_o
);

    localparam int MW = MB_SEL + SELW;

    typedef struct packed {
        logic [MW-1:0] mode;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cnt_rl;
        logic [AW-1:0] mem;
        logic [AW-1:0] periph;
        logic [AW-1:0] mem_rl;
        logic          tc;
    } chan_t;

    chan_t         q, d;
    logic [CW-1:0] cnt_dec;
    logic [AW-1:0] stride;

    always_comb begin
        d       = q;
        d.tc    = 1'b0;
        cnt_dec = q.cnt - CW'(1);
        stride  = q.mode[MB_WORD] ? AW'(2) : AW'(1);

        if (step) begin
            if (cnt_dec == '0) begin
                d.cnt = q.cnt_rl;
                d.mem = q.mem_rl;
                d.tc  = 1'b1;
            end else begin
                d.cnt = cnt_dec;
                if (q.mode[MB_INC]) begin
                    d.mem = q.mem + stride;
                end
            end
        end

        if (wr_en) begin
            case (wr_idx)
                RIDX_MODE:     d.mode   = wr_data[MW-1:0];
                RIDX_COUNT:    d.cnt    = wr_data[CW-1:0];
                RIDX_COUNT_RL: d.cnt_rl = wr_data[CW-1:0];
                RIDX_MEM:      d.mem    = wr_data;
                RIDX_PERIPH:   d.periph = wr_data;
                RIDX_MEM_RL:   d.mem_rl = wr_data;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dir_o    = q.mode[MB_DIR];
    assign word_o   = q.mode[MB_WORD];
    assign hwen_o   = q.mode[MB_HWEN];
    assign sel_o    = q.mode[MB_SEL +: SELW];
    assign mem_o    = q.mem;
    assign periph_o = q.periph;
    assign tc_o     = q.tc;

endmodule

// File: rtl/steal_dma_req.sv
module steal_dma_req #(
    parameter int NCH  = 4,
    parameter int NSRC = 8,
    parameter int SELW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     irq_in,
    input  logic [NCH-1:0]      sw_req,
    input  logic [NCH-1:0]      hw_en,
    input  logic [NCH*SELW-1:0] src_sel,
    input  logic [NCH-1:0]      clr,
    output logic [NCH-1:0]      pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] irq_prev;
        logic [NCH-1:0]  pend;
    } req_t;

    req_t            q, d;
    logic [NSRC-1:0] rise;
    logic [NCH-1:0]  hit;

    assign rise = irq_in & ~q.irq_prev;

    for (genvar c = 0; c < NCH; c++) begin : g_hit
        logic [NSRC-1:0] sel_mask;
        assign sel_mask = NSRC'(1) << src_sel[c*SELW +: SELW];
        assign hit[c]   = hw_en[c] & (|(rise & sel_mask));
    end

    always_comb begin
        d          = q;
        d.irq_prev = irq_in;
        // a new trigger in the grant cycle survives as the next request
        d.pend     = (q.pend & ~clr) | hit | sw_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend_o = q.pend;

endmodule

// File: rtl/steal_dma_arb.sv
module steal_dma_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] gnt,
    output logic [IW-1:0]  idx,
    output logic           any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        // walk down so the lowest pending index is the last one kept
        for (int c = NCH - 1; c >= 0; c--) begin
            if (req[c]) begin
                gnt = NCH'(1) << c;
                idx = IW'(c);
            end
        end
    end

endmodule

// File: rtl/steal_dma.sv
module steal_dma
    import steal_dma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NSRC = 8,
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 16,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [2:0]      cfg_idx,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [NCH-1:0]  sw_req,
    input  logic [NSRC-1:0] irq_in,
    input  logic            cpu_req,
    output logic            cpu_gnt,
    output logic            bus_valid,
    output logic            bus_we,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic [NCH-1:0]  tc_pulse
);

    typedef struct packed {
        xfer_state_e    state;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  data;
    } xfer_t;

    xfer_t                q, d;

    logic [NCH-1:0]       dir_v, word_v, hwen_v, tc_v;
    logic [NCH*SELW-1:0]  sel_flat;
    logic [AW-1:0]        mem_v    [NCH];
    logic [AW-1:0]        periph_v [NCH];
    logic [NCH-1:0]       pend_v, clr_v, step_v, arb_gnt;
    logic [CHW-1:0]       arb_idx;
    logic                 arb_any;
    logic                 cur_dir, cur_word, to_mem;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        steal_dma_chan #(
            .AW   (AW),
            .CW   (CW),
            .SELW (SELW)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_ch == CHW'(c))),
            .wr_idx   (cfg_idx),
            .wr_data  (cfg_wdata),
            .step     (step_v[c]),
            .dir_o    (dir_v[c]),
            .word_o   (word_v[c]),
            .hwen_o   (hwen_v[c]),
            .sel_o    (sel_flat[c*SELW +: SELW]),
            .mem_o    (mem_v[c]),
            .periph_o (periph_v[c]),
            .tc_o     (tc_v[c])
        );
    end

    steal_dma_req #(
        .NCH  (NCH),
        .NSRC (NSRC),
        .SELW (SELW)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .sw_req  (sw_req),
        .hw_en   (hwen_v),
        .src_sel (sel_flat),
        .clr     (clr_v),
        .pend_o  (pend_v)
    );

    steal_dma_arb #(
        .NCH (NCH),
        .IW  (CHW)
    ) u_arb (
        .req (pend_v),
        .gnt (arb_gnt),
        .idx (arb_idx),
        .any (arb_any)
    );

    assign cur_dir  = dir_v[q.ch];
    assign cur_word = word_v[q.ch];

    always_comb begin
        d      = q;
        clr_v  = '0;
        step_v = '0;
        case (q.state)
            XS_IDLE: begin
                if (arb_any) begin
                    d.state = XS_READ;
                    d.ch    = arb_idx;
                    clr_v   = arb_gnt;
                end
            end
            XS_READ: begin
                d.data  = cur_word ? bus_rdata
                                   : {{(DW-8){1'b0}}, bus_rdata[7:0]};
                d.state = XS_WRITE;
            end
            XS_WRITE: begin
                step_v  = NCH'(1) << q.ch;
                d.state = XS_IDLE;
            end
            default: d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: XS_IDLE, ch: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_valid = (q.state != XS_IDLE);
        bus_we    = (q.state == XS_WRITE);
        to_mem    = bus_we ^ cur_dir;
        bus_addr  = '0;
        if (bus_valid) begin
            bus_addr = to_mem ? mem_v[q.ch] : periph_v[q.ch];
        end
        bus_wdata = bus_we ? q.data : '0;
        bus_word  = bus_valid & cur_word;
        cpu_gnt   = cpu_req & (q.state == XS_IDLE) & ~arb_any;
    end

    assign tc_pulse = tc_v;

endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_req,
    input logic           cpu_gnt,
    input logic           bus_valid,
    input logic           bus_we,
    input logic [NCH-1:0] tc_pulse
);

    AST_GNT_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> !bus_valid); // R8

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> cpu_req); // R8

    AST_WE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_valid); // R2

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> (bus_valid && bus_we)); // R2

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we) |=> !bus_valid); // R7

    AST_TC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_pulse)); // R6

    AST_TC_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_pulse) |-> $past(bus_valid && bus_we)); // R6

endmodule

bind steal_dma steal_dma_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_gnt   (cpu_gnt),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .tc_pulse  (tc_pulse)
);

// File: tb/steal_dma_tb.sv
module steal_dma_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_ch;
    logic [2:0]  cfg_idx;
    logic [15:0] cfg_wdata;
    logic [3:0]  sw_req;
    logic [7:0]  irq_in;
    logic        cpu_req;
    logic        cpu_gnt;
    logic        bus_valid;
    logic        bus_we;
    logic        bus_word;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [3:0]  tc_pulse;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;

    steal_dma u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .sw_req    (sw_req),
        .irq_in    (irq_in),
        .cpu_req   (cpu_req),
        .cpu_gnt   (cpu_gnt),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tc_pulse  (tc_pulse)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // memory and peripherals answer with a scrambled copy of the address
    always_comb bus_rdata = bus_addr ^ 16'h5AC3;

    always @(negedge clk) begin
        if (bus_valid && !bus_we) rd_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input logic [2:0] idx, input logic [15:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_ch    = 2'(ch);
        cfg_idx   = idx;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic program_ch(input int ch, input logic [15:0] mode, input logic [15:0] cnt,
                              input logic [15:0] cnt_rl, input logic [15:0] mem,
                              input logic [15:0] periph, input logic [15:0] mem_rl);
        cfg_write(ch, 3'd0, mode);
        cfg_write(ch, 3'd1, cnt);
        cfg_write(ch, 3'd2, cnt_rl);
        cfg_write(ch, 3'd3, mem);
        cfg_write(ch, 3'd4, periph);
        cfg_write(ch, 3'd5, mem_rl);
    endtask

    // one software-triggered transfer, checked cycle by cycle
    task automatic run_one(input int ch, input logic [15:0] src, input logic [15:0] dst,
                           input logic word, input logic tc);
        logic [15:0] exp_data;
        exp_data = word ? (src ^ 16'h5AC3) : ((src ^ 16'h5AC3) & 16'h00FF);
        @(negedge clk);
        sw_req[ch] = 1'b1;
        @(negedge clk);
        sw_req[ch] = 1'b0;
        chk("R2 bus idle while request waits", {31'd0, bus_valid}, 32'd0);
        chk("R8 grant withheld while pending", {31'd0, cpu_gnt}, 32'd0);
        @(negedge clk);
        chk("R2 read cycle", {30'd0, bus_valid, bus_we}, 32'd2);
        chk("R3 read address", {16'd0, bus_addr}, {16'd0, src});
        chk("R4 unit size", {31'd0, bus_word}, {31'd0, word});
        chk("R8 grant withheld in read", {31'd0, cpu_gnt}, 32'd0);
        @(negedge clk);
        chk("R2 write cycle", {30'd0, bus_valid, bus_we}, 32'd3);
        chk("R3 write address", {16'd0, bus_addr}, {16'd0, dst});
        chk("R4 write data", {16'd0, bus_wdata}, {16'd0, exp_data});
        chk("R8 grant withheld in write", {31'd0, cpu_gnt}, 32'd0);
        @(negedge clk);
        chk("R6 terminal count pulse", {28'd0, tc_pulse}, tc ? (32'd1 << ch) : 32'd0);
        chk("R2 bus released", {31'd0, bus_valid}, 32'd0);
        chk("R8 grant returns", {31'd0, cpu_gnt}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_ch    = '0;
        cfg_idx   = '0;
        cfg_wdata = '0;
        sw_req    = '0;
        irq_in    = '0;
        cpu_req   = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 bus idle", {31'd0, bus_valid}, 32'd0);
        chk("R11 no tc", {28'd0, tc_pulse}, 32'd0);
        chk("R11 grant follows request", {31'd0, cpu_gnt}, 32'd1);

        // R1 R3 R4 R5 R6: every channel through all direction/increment/size modes
        for (int ch = 0; ch < 4; ch++) begin
            for (int m = 0; m < 8; m++) begin
                logic        dir, inc, word;
                logic [15:0] base, mrl, per, mexp, step, src, dst;
                int          cnt;
                dir  = m[0];
                inc  = m[1];
                word = m[2];
                base = 16'h1000 + 16'(ch * 256) + 16'(m * 16);
                mrl  = 16'h8000 + 16'(ch * 256) + 16'(m * 16);
                per  = 16'h0400 + 16'(ch * 64) + 16'(m * 4);
                step = word ? 16'd2 : 16'd1;
                program_ch(ch, 16'(m), 16'd3, 16'd2, base, per, mrl);
                mexp = base;
                cnt  = 3;
                for (int k = 0; k < 5; k++) begin
                    src = dir ? mexp : per;
                    dst = dir ? per : mexp;
                    run_one(ch, src, dst, word, cnt == 1);
                    if (cnt == 1) begin
                        cnt  = 2;
                        mexp = mrl;
                    end else begin
                        cnt--;
                        if (inc) mexp = mexp + step;
                    end
                end
            end
        end

        // R7: fixed priority across simultaneous requests
        for (int ch = 0; ch < 4; ch++) begin
            program_ch(ch, 16'h0004, 16'd100, 16'd100, 16'h2000, 16'h0200 + 16'(ch), 16'h2000);
        end
        @(negedge clk);
        sw_req = 4'hF;
        @(negedge clk);
        sw_req = 4'h0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 service order read address", {16'd0, bus_addr}, 32'h0200 + 32'(i));
            @(negedge clk);
            @(negedge clk);
            chk("R7 idle gap between transfers", {31'd0, bus_valid}, 32'd0);
            chk("R8 grant only when queue empty", {31'd0, cpu_gnt}, (i == 3) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        sw_req = 4'b1010;
        @(negedge clk);
        sw_req = 4'h0;
        @(negedge clk);
        chk("R7 lower channel of subset first", {16'd0, bus_addr}, 32'h0201);
        repeat (3) @(negedge clk);
        chk("R7 higher channel of subset second", {16'd0, bus_addr}, 32'h0203);
        repeat (4) @(negedge clk);

        // R10: three strobes during one window merge into two transfers
        rd_cnt = 0;
        @(negedge clk);
        sw_req[0] = 1'b1;
        @(negedge clk);
        sw_req[0] = 1'b0;
        @(negedge clk);
        sw_req[0] = 1'b1;
        @(negedge clk);
        sw_req[0] = 1'b1;
        @(negedge clk);
        sw_req[0] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10 merged request count", 32'(rd_cnt), 32'd2);

        // R9: interrupt-line triggering on channel 2, line 5
        program_ch(2, 16'h005C, 16'd100, 16'd100, 16'h3000, 16'h0300, 16'h3000);
        rd_cnt = 0;
        @(negedge clk);
        irq_in[5] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 held level gives one transfer", 32'(rd_cnt), 32'd1);
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        irq_in[5] = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 second edge gives second transfer", 32'(rd_cnt), 32'd2);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            irq_in[3] = 1'b1;
            @(negedge clk);
            irq_in[3] = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk("R9 unselected line ignored", 32'(rd_cnt), 32'd2);
        irq_in[5] = 1'b0;
        cfg_write(2, 3'd0, 16'h0054);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            irq_in[5] = 1'b1;
            @(negedge clk);
            irq_in[5] = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk("R9 edges ignored with enable clear", 32'(rd_cnt), 32'd2);
        chk("R8 grant after quiet edges", {31'd0, cpu_gnt}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule